// File: doc/BRIEF.md
# Flash Programming Access Controller

This block lets an external programmer reach the on-chip program flash while the chip is held in its programming strap mode. It decodes a fixed combination of mode straps, four control straps, a chip-enable, an output-enable and a high-voltage-present flag into one of three operations: read, program and program-verify. For reads and verifies it strobes a flash array and returns the byte on an output bus with a drive enable. For programming it waits for stable setup of address and data, then issues one program pulse of fixed length derived from the clock frequency.

A separate option byte sits above the array (address bit 15 set). Bit 0 is the active-low lock flag and bit 1 is the table-read freedom flag. Both start erased (1) and programming can only clear bits. Once the lock is cleared, every read or verify returns 0xFF without touching the array, and main-array programming produces no pulse. The table-read rule is a CPU-side check. A table read that runs from external code and targets internal memory is refused while the freedom flag is 0. A refused read returns 0xFF.

The state machine has seven states. IDLE waits for an operation. READ and VERIFY follow their operation while it is held. SETUP counts stable setup cycles. PULSE drives the program strobe. HOLD waits for the program request to go away after a completed or refused program. ABORT waits for release after an interrupted pulse. The named transitions are:
- start-read: IDLE to READ.
- start-verify: IDLE to VERIFY.
- start-program: IDLE to SETUP.
- refuse-locked: IDLE or SETUP to HOLD.
- cancel-setup: SETUP to IDLE.
- fire: SETUP to PULSE.
- complete: PULSE to HOLD.
- abort: PULSE to ABORT.
- release: READ, VERIFY, HOLD or ABORT to IDLE.

Top module: `flash_prog_ctrl`

## Requirements
- R1: An operation is decoded only when strap_rst=1, strap_ale=0 and strap_psen=1, and ctl_a9, ctl_a13, ctl_a14 and ctl_oe are all 0. Under any other strap combination no flash strobe is raised and dout_oe stays 0.
- R2: Read is selected by ce_n=0, oe_n=0 and vpp_hv=0. fl_rd is raised and, within three clock edges, dout carries the array byte at addr[14:0] with dout_oe=1.
- R3: Program is selected by ce_n=0, oe_n=1 and vpp_hv=1. After setup, fl_pgm is high for exactly PULSE_US*CLK_HZ/1e6 cycles, carrying the latched address and data. Only one pulse is issued for each program request, however long it is held.
- R4: The pulse starts only after addr and din have been stable for SETUP_US*CLK_HZ/1e6 cycles. Any change during setup restarts the count, and the byte written is the one present at the end of setup.
- R5: Verify is selected by ce_n=1, oe_n=0 and vpp_hv=1. fl_vfy is raised and dout returns the stored byte with dout_oe=1.
- R6: If the program request is lost during the pulse (for example vpp_hv falls), fl_pgm drops within two edges and pgm_err becomes 1. pgm_err clears when the next program request starts setup.
- R7: The option byte is addressed when addr[15]=1. Bit 0 is the active-low lock and bit 1 is the table-read freedom flag. It reads back 0xFF after reset, and programming it ANDs din into it, so bits can be cleared but never set.
- R8: With the lock bit 0, every read and verify returns dout=0xFF with dout_oe=1 and without fl_rd or fl_vfy. Main-array programming raises no fl_pgm. The lock stays 0 until rst_n.
- R9: With movc_req=1, movc_src_int=0, movc_tgt_int=1 and the freedom flag 0, movc_allow=0 and movc_rdata=0xFF. In every other requesting case movc_allow=1 and movc_rdata=movc_mem_data.
- R10: At most one of fl_rd, fl_vfy and fl_pgm is high in any cycle.
- R11: After reset, dout_oe=0, dout=0xFF, all strobes are 0 and pgm_err=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the controller and option byte |
| strap_rst | input | 1 | Mode strap, must be 1 |
| strap_ale | input | 1 | Mode strap, must be 0 |
| strap_psen | input | 1 | Mode strap, must be 1 |
| ctl_a9 | input | 1 | Control strap, must be 0 |
| ctl_a13 | input | 1 | Control strap, must be 0 |
| ctl_a14 | input | 1 | Control strap, must be 0 |
| ctl_oe | input | 1 | Control strap, must be 0 |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| vpp_hv | input | 1 | 1 when programming voltage is elevated |
| addr | input | 16 | Programmer address; bit 15 selects option byte |
| din | input | 8 | Programmer write data |
| dout | output | 8 | Read or verify data |
| dout_oe | output | 1 | Drive enable for dout |
| fl_addr | output | 15 | Array address |
| fl_rd | output | 1 | Array read strobe |
| fl_vfy | output | 1 | Array verify strobe |
| fl_pgm | output | 1 | Array program pulse |
| fl_wdata | output | 8 | Array program data |
| fl_rdata | input | 8 | Array read data |
| pgm_err | output | 1 | Last pulse was interrupted |
| movc_req | input | 1 | CPU table read request |
| movc_src_int | input | 1 | Request issued from internal code |
| movc_tgt_int | input | 1 | Request targets internal memory |
| movc_mem_data | input | 8 | Byte fetched for the table read |
| movc_allow | output | 1 | Table read permitted |
| movc_rdata | output | 8 | Table read result |

## Verification
Reads are applied at two addresses with different byte values, so a stuck or shifted data path shows up. The same read pins are then applied under three wrong strap settings, which separates the mode gate from the operation decode. Programming is tried three ways: with constant inputs, which checks the exact pulse length; with data changed mid-setup, which shows whether setup restarts and which byte lands; and with the voltage dropped mid-pulse, which exercises abort and error clearing. The option byte is first cleared bit by bit and then rewritten with ones, which separates AND-only programming from a plain write. The table-read rule is run over all source and target combinations, before and after the freedom flag is cleared.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
    typedef enum logic [1:0] {
        OP_NONE,
        OP_READ,
        OP_PROG,
        OP_VFY
    } fpc_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_VERIFY,
        ST_SETUP,
        ST_PULSE,
        ST_HOLD,
        ST_ABORT
    } fpc_state_e;
endpackage

// File: rtl/fpc_strap_decode.sv
module fpc_strap_decode
    import fpc_pkg::*;
(
    input  logic    strap_rst,
    input  logic    strap_ale,
    input  logic    strap_psen,
    input  logic    ctl_a9,
    input  logic    ctl_a13,
    input  logic    ctl_a14,
    input  logic    ctl_oe,
    input  logic    ce_n,
    input  logic    oe_n,
    input  logic    vpp_hv,
    output fpc_op_e op
);
    logic mode_ok;
    logic ctl_clear;

    assign mode_ok   = strap_rst & ~strap_ale & strap_psen;
    assign ctl_clear = ~(ctl_a9 | ctl_a13 | ctl_a14 | ctl_oe);

    always_comb begin
        op = OP_NONE;
        if (mode_ok && ctl_clear) begin
            unique case ({ce_n, oe_n, vpp_hv})
                3'b000:  op = OP_READ;
                3'b011:  op = OP_PROG;
                3'b101:  op = OP_VFY;
                default: op = OP_NONE;
            endcase
        end
    end
endmodule

// File: rtl/fpc_cycle_timer.sv
module fpc_cycle_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en,
    output logic [CW-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (en)  cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/fpc_option_store.sv
module fpc_option_store #(
    parameter int DATA_W   = 8,
    parameter int LOCK_BIT = 0,
    parameter int OPEN_BIT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] opt_q,
    output logic              locked,
    input  logic              movc_req,
    input  logic              movc_src_int,
    input  logic              movc_tgt_int,
    input  logic [DATA_W-1:0] movc_mem_data,
    output logic              movc_allow,
    output logic [DATA_W-1:0] movc_rdata
);
    logic movc_open;
    logic movc_deny;

    // Flash cells: programming can only clear bits.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  opt_q <= '1;
        else if (wr) opt_q <= opt_q & wdata;
    end

    assign locked     = ~opt_q[LOCK_BIT];
    assign movc_open  = opt_q[OPEN_BIT];
    assign movc_deny  = ~movc_src_int & movc_tgt_int & ~movc_open;
    assign movc_allow = movc_req & ~movc_deny;
    assign movc_rdata = movc_allow ? movc_mem_data : '1;

    assert_lock_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked);

    assert_bits_only_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (opt_q & ~$past(opt_q)) == '0);

    assert_internal_source_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (movc_req && movc_src_int) |-> (movc_allow && movc_rdata == movc_mem_data));
endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
    import fpc_pkg::*;
#(
    parameter int CLK_HZ   = 250_000_000,
    parameter int PULSE_US = 300,
    parameter int SETUP_US = 2,
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_rst,
    input  logic              strap_ale,
    input  logic              strap_psen,
    input  logic              ctl_a9,
    input  logic              ctl_a13,
    input  logic              ctl_a14,
    input  logic              ctl_oe,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              vpp_hv,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe,
    output logic [ADDR_W-2:0] fl_addr,
    output logic              fl_rd,
    output logic              fl_vfy,
    output logic              fl_pgm,
    output logic [DATA_W-1:0] fl_wdata,
    input  logic [DATA_W-1:0] fl_rdata,
    output logic              pgm_err,
    input  logic              movc_req,
    input  logic              movc_src_int,
    input  logic              movc_tgt_int,
    input  logic [DATA_W-1:0] movc_mem_data,
    output logic              movc_allow,
    output logic [DATA_W-1:0] movc_rdata
);
    localparam int CYC_PER_US = CLK_HZ / 1_000_000;
    localparam int PULSE_CYC  = CYC_PER_US * PULSE_US;
    localparam int SETUP_CYC  = CYC_PER_US * SETUP_US;
    localparam int MAX_CYC    = (PULSE_CYC > SETUP_CYC) ? PULSE_CYC : SETUP_CYC;
    localparam int CW         = $clog2(MAX_CYC + 1);
    localparam int AW         = ADDR_W - 1;

    fpc_op_e    op_d, op_q;
    fpc_state_e state_q, state_d;

    logic [CW-1:0]     cnt;
    logic              tmr_clr, tmr_en;
    logic [ADDR_W-1:0] addr_q, lat_addr;
    logic [DATA_W-1:0] din_q, lat_data;
    logic              lat_opt;
    logic              opt_sel, chg, setup_done, pulse_done;
    logic              opt_wr, locked;
    logic [DATA_W-1:0] opt_q;

    fpc_strap_decode u_decode (
        .strap_rst (strap_rst),
        .strap_ale (strap_ale),
        .strap_psen(strap_psen),
        .ctl_a9    (ctl_a9),
        .ctl_a13   (ctl_a13),
        .ctl_a14   (ctl_a14),
        .ctl_oe    (ctl_oe),
        .ce_n      (ce_n),
        .oe_n      (oe_n),
        .vpp_hv    (vpp_hv),
        .op        (op_d)
    );

    fpc_cycle_timer #(.CW(CW)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (tmr_clr),
        .en   (tmr_en),
        .cnt  (cnt)
    );

    fpc_option_store #(.DATA_W(DATA_W)) u_opt (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr           (opt_wr),
        .wdata        (lat_data),
        .opt_q        (opt_q),
        .locked       (locked),
        .movc_req     (movc_req),
        .movc_src_int (movc_src_int),
        .movc_tgt_int (movc_tgt_int),
        .movc_mem_data(movc_mem_data),
        .movc_allow   (movc_allow),
        .movc_rdata   (movc_rdata)
    );

    assign opt_sel    = addr[ADDR_W-1];
    assign chg        = (addr != addr_q) || (din != din_q);
    assign setup_done = !chg && (cnt == CW'(SETUP_CYC - 1));
    assign pulse_done = (cnt == CW'(PULSE_CYC - 1));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                unique case (op_q)
                    OP_READ: state_d = ST_READ;
                    OP_VFY:  state_d = ST_VERIFY;
                    OP_PROG: state_d = (locked && !opt_sel) ? ST_HOLD : ST_SETUP;
                    default: state_d = ST_IDLE;
                endcase
            end
            ST_READ:   if (op_q != OP_READ) state_d = ST_IDLE;
            ST_VERIFY: if (op_q != OP_VFY)  state_d = ST_IDLE;
            ST_SETUP: begin
                if (op_q != OP_PROG)       state_d = ST_IDLE;
                else if (setup_done)       state_d = (locked && !opt_sel) ? ST_HOLD : ST_PULSE;
            end
            ST_PULSE: begin
                if (op_q != OP_PROG)       state_d = ST_ABORT;
                else if (pulse_done)       state_d = ST_HOLD;
            end
            ST_HOLD:   if (op_q != OP_PROG) state_d = ST_IDLE;
            ST_ABORT:  if (op_q != OP_PROG) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs and timer control
    always_comb begin
        fl_rd    = 1'b0;
        fl_vfy   = 1'b0;
        fl_pgm   = 1'b0;
        opt_wr   = 1'b0;
        tmr_clr  = 1'b1;
        tmr_en   = 1'b0;
        fl_addr  = addr[AW-1:0];
        fl_wdata = lat_data;
        unique case (state_q)
            ST_READ:   fl_rd  = !locked && !opt_sel;
            ST_VERIFY: fl_vfy = !locked && !opt_sel;
            ST_SETUP: begin
                tmr_clr = chg || setup_done;
                tmr_en  = !tmr_clr;
            end
            ST_PULSE: begin
                fl_pgm  = !lat_opt;
                fl_addr = lat_addr[AW-1:0];
                tmr_clr = 1'b0;
                tmr_en  = 1'b1;
                opt_wr  = lat_opt && pulse_done && (op_q == OP_PROG);
            end
            default: ;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q     <= OP_NONE;
            addr_q   <= '0;
            din_q    <= '0;
            lat_addr <= '0;
            lat_data <= '1;
            lat_opt  <= 1'b0;
            pgm_err  <= 1'b0;
            dout     <= '1;
            dout_oe  <= 1'b0;
        end else begin
            op_q   <= op_d;
            addr_q <= addr;
            din_q  <= din;
            if (state_q == ST_SETUP && state_d == ST_PULSE) begin
                lat_addr <= addr;
                lat_data <= din;
                lat_opt  <= opt_sel;
            end
            if (state_q == ST_PULSE && state_d == ST_ABORT)      pgm_err <= 1'b1;
            else if (state_q == ST_IDLE && state_d == ST_SETUP)  pgm_err <= 1'b0;
            if (state_q == ST_READ || state_q == ST_VERIFY) begin
                dout_oe <= 1'b1;
                dout    <= locked ? '1 : (opt_sel ? opt_q : fl_rdata);
            end else begin
                dout_oe <= 1'b0;
                dout    <= '1;
            end
        end
    end

    // Checker state: length of the current program pulse
    int unsigned plen;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      plen <= 0;
        else if (fl_pgm) plen <= plen + 1;
        else             plen <= 0;
    end

    assert_one_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fl_rd, fl_vfy, fl_pgm}));

    assert_pulse_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(fl_pgm) && !pgm_err) |-> (plen == PULSE_CYC));

    assert_abort_on_loss_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PULSE && op_q != OP_PROG) |=> (!fl_pgm && pgm_err));

    assert_locked_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> (!fl_rd && !fl_vfy && !fl_pgm));

    assert_read_needs_mode_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fl_rd |-> ($past(strap_rst, 2) && !$past(strap_ale, 2) && $past(strap_psen, 2)));

    assert_locked_dout_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_oe && locked) |-> (dout == '1));
endmodule

// File: tb/flash_prog_ctrl_test.sv
module flash_prog_ctrl_test;
    localparam int CLK_HZ = 10_000_000;  // scaled so pulses stay short in the bench
    localparam int PULSE_CYC = (CLK_HZ / 1_000_000) * 300;
    localparam int SETUP_CYC = (CLK_HZ / 1_000_000) * 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic strap_rst = 1'b1, strap_ale = 1'b0, strap_psen = 1'b1;
    logic ctl_a9 = 1'b0, ctl_a13 = 1'b0, ctl_a14 = 1'b0, ctl_oe = 1'b0;
    logic ce_n = 1'b1, oe_n = 1'b1, vpp_hv = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  din = '0;
    logic [7:0]  dout;
    logic        dout_oe;
    logic [14:0] fl_addr;
    logic        fl_rd, fl_vfy, fl_pgm;
    logic [7:0]  fl_wdata, fl_rdata;
    logic        pgm_err;
    logic        movc_req = 1'b0, movc_src_int = 1'b0, movc_tgt_int = 1'b0;
    logic [7:0]  movc_mem_data = 8'hA7;
    logic        movc_allow;
    logic [7:0]  movc_rdata;

    int checks = 0;
    int errors = 0;

    logic [7:0] mem [256];
    assign fl_rdata = mem[fl_addr[7:0]];

    always #2 clk = ~clk;  // 250 MHz

    flash_prog_ctrl #(.CLK_HZ(CLK_HZ)) uut (
        .clk(clk), .rst_n(rst_n),
        .strap_rst(strap_rst), .strap_ale(strap_ale), .strap_psen(strap_psen),
        .ctl_a9(ctl_a9), .ctl_a13(ctl_a13), .ctl_a14(ctl_a14), .ctl_oe(ctl_oe),
        .ce_n(ce_n), .oe_n(oe_n), .vpp_hv(vpp_hv),
        .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe),
        .fl_addr(fl_addr), .fl_rd(fl_rd), .fl_vfy(fl_vfy), .fl_pgm(fl_pgm),
        .fl_wdata(fl_wdata), .fl_rdata(fl_rdata), .pgm_err(pgm_err),
        .movc_req(movc_req), .movc_src_int(movc_src_int), .movc_tgt_int(movc_tgt_int),
        .movc_mem_data(movc_mem_data), .movc_allow(movc_allow), .movc_rdata(movc_rdata)
    );

    // Array model and pulse monitor
    int cur_len = 0, last_len = 0, pulses = 0, strobe_bad = 0;
    logic [7:0] cap_addr, cap_data;
    always @(negedge clk) begin
        if ((int'(fl_rd) + int'(fl_vfy) + int'(fl_pgm)) > 1) strobe_bad++;
        if (fl_pgm) begin
            cur_len++;
            cap_addr = fl_addr[7:0];
            cap_data = fl_wdata;
        end else if (cur_len > 0) begin
            last_len = cur_len;
            pulses++;
            if (cur_len == PULSE_CYC) mem[cap_addr] = mem[cap_addr] & cap_data;
            cur_len = 0;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic go_idle();
        @(negedge clk);
        strap_rst = 1'b1; strap_ale = 1'b0; strap_psen = 1'b1;
        ctl_a9 = 1'b0; ctl_a13 = 1'b0; ctl_a14 = 1'b0; ctl_oe = 1'b0;
        ce_n = 1'b1; oe_n = 1'b1; vpp_hv = 1'b0;
        cyc(4);
    endtask

    task automatic do_read(input logic [15:0] a);
        @(negedge clk);
        addr = a; ce_n = 1'b0; oe_n = 1'b0; vpp_hv = 1'b0;
        cyc(5);
    endtask

    task automatic do_verify(input logic [15:0] a);
        @(negedge clk);
        addr = a; vpp_hv = 1'b1; ce_n = 1'b1; oe_n = 1'b0;
        cyc(5);
    endtask

    task automatic do_program(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; din = d; vpp_hv = 1'b1; oe_n = 1'b1; ce_n = 1'b0;
        cyc(SETUP_CYC + PULSE_CYC + 140);
        go_idle();
    endtask

    task automatic t_reset();
        chk("R11 dout_oe", dout_oe, 0);
        chk("R11 dout", dout, 8'hFF);
        chk("R11 strobes", {fl_rd, fl_vfy, fl_pgm}, 0);
        chk("R11 pgm_err", pgm_err, 0);
    endtask

    task automatic t_read();
        do_read(16'h0012);
        chk("R2 fl_rd", fl_rd, 1);
        chk("R2 dout_oe", dout_oe, 1);
        chk("R2 data 12", dout, 8'h5A);
        do_read(16'h0034);
        chk("R2 data 34", dout, 8'hC3);
        go_idle();
    endtask

    task automatic t_mode_gate();
        @(negedge clk); strap_ale = 1'b1;
        do_read(16'h0012);
        chk("R1 ale high", {dout_oe, fl_rd}, 0);
        go_idle();
        @(negedge clk); ctl_a13 = 1'b1;
        do_read(16'h0012);
        chk("R1 ctl strap high", {dout_oe, fl_rd}, 0);
        go_idle();
        @(negedge clk); strap_psen = 1'b0;
        do_read(16'h0012);
        chk("R1 psen low", {dout_oe, fl_rd}, 0);
        go_idle();
    endtask

    task automatic t_program();
        int p0 = pulses;
        do_program(16'h0020, 8'h3C);
        chk("R3 one pulse", pulses - p0, 1);
        chk("R3 pulse length", last_len, PULSE_CYC);
        chk("R3 latched addr", cap_addr, 8'h20);
        chk("R3 latched data", cap_data, 8'h3C);
        do_verify(16'h0020);
        chk("R5 fl_vfy", fl_vfy, 1);
        chk("R5 verify data", dout, 8'h3C);
        go_idle();
    endtask

    task automatic t_setup_restart();
        int n = 0;
        @(negedge clk);
        addr = 16'h0021; din = 8'h0F; vpp_hv = 1'b1; oe_n = 1'b1; ce_n = 1'b0;
        cyc(10);
        din = 8'h55;
        while (!fl_pgm && n < 200) begin @(negedge clk); n++; end
        chk("R4 restart low", (n >= SETUP_CYC), 1);
        chk("R4 restart high", (n <= SETUP_CYC + 2), 1);
        cyc(PULSE_CYC + 20);
        go_idle();
        do_verify(16'h0021);
        chk("R4 data at end of setup", dout, 8'h55);
        go_idle();
    endtask

    task automatic t_abort();
        int n = 0;
        @(negedge clk);
        addr = 16'h0022; din = 8'h00; vpp_hv = 1'b1; oe_n = 1'b1; ce_n = 1'b0;
        while (!fl_pgm && n < 200) begin @(negedge clk); n++; end
        cyc(50);
        vpp_hv = 1'b0;
        cyc(4);
        chk("R6 pulse dropped", fl_pgm, 0);
        chk("R6 error set", pgm_err, 1);
        go_idle();
        @(negedge clk);
        addr = 16'h0023; din = 8'hF0; vpp_hv = 1'b1; oe_n = 1'b1; ce_n = 1'b0;
        cyc(5);
        chk("R6 error cleared", pgm_err, 0);
        cyc(SETUP_CYC + PULSE_CYC + 20);
        go_idle();
    endtask

    task automatic t_movc_option();
        @(negedge clk); movc_req = 1'b1; movc_src_int = 1'b0; movc_tgt_int = 1'b1;
        @(negedge clk);
        chk("R9 open allows", {movc_allow, movc_rdata}, {1'b1, 8'hA7});
        do_program(16'h8000, 8'hFD);
        do_read(16'h8000);
        chk("R7 option readback", dout, 8'hFD);
        go_idle();
        chk("R9 denied", {movc_allow, movc_rdata}, {1'b0, 8'hFF});
        @(negedge clk); movc_src_int = 1'b1;
        @(negedge clk);
        chk("R9 internal source", {movc_allow, movc_rdata}, {1'b1, 8'hA7});
        @(negedge clk); movc_src_int = 1'b0; movc_tgt_int = 1'b0;
        @(negedge clk);
        chk("R9 external target", {movc_allow, movc_rdata}, {1'b1, 8'hA7});
        do_program(16'h8000, 8'hFF);
        do_read(16'h8000);
        chk("R7 bits not set", dout, 8'hFD);
        go_idle();
    endtask

    task automatic t_lock();
        int p0;
        do_program(16'h8000, 8'hFE);
        do_read(16'h8000);
        chk("R8 option hidden", dout, 8'hFF);
        do_read(16'h0012);
        chk("R8 read blocked", {dout_oe, fl_rd, dout}, {1'b1, 1'b0, 8'hFF});
        go_idle();
        p0 = pulses;
        do_program(16'h0024, 8'h00);
        chk("R8 no pulse", pulses - p0, 0);
        do_verify(16'h0020);
        chk("R8 verify blocked", {fl_vfy, dout}, {1'b0, 8'hFF});
        go_idle();
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
        mem[8'h12] = 8'h5A;
        mem[8'h34] = 8'hC3;
        cyc(3);
        t_reset();
        rst_n = 1'b1;
        go_idle();
        t_read();
        t_mode_gate();
        t_program();
        t_setup_restart();
        t_abort();
        t_movc_option();
        t_lock();
        chk("R10 single strobe", strobe_bad, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        cyc(190_000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule